// File: doc/BRIEF.md
# Calendar Clock with Update Cycle

This block keeps the time of day and the calendar (seconds, minutes, hours, day of week, day of month, month, two-digit year and century). It runs from a single-cycle enable that pulses at the 32768 Hz time-base rate. Once per second it advances the count and carries through minutes, hours, days, months, years and centuries. The carry into the next month follows the length of the current month, and February has 29 days in years divisible by four.

Software reaches the block through a byte-wide register file with a write strobe and a combinational read. Two control registers set the behaviour. The first holds a divider-control field and the read-only update-in-progress flag. The second holds the freeze bit, the binary/BCD selector and the 12/24-hour selector. The counters are kept in binary inside the block. Every time and date byte is converted to the selected format when it is read or written.

There are three ways to stop the count. A freeze bit lets software load a consistent time, and clearing it restarts the second from zero. An out-of-range divider field halts counting. A divider-reset code halts counting and, when it is removed, puts the first update half a second away. The update-in-progress flag is raised for the last few time-base ticks of every second, so software can avoid reading while the registers are about to change.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, control register A (address 8) reads 0x26, control register B (address 9) reads 0x02 and status register D (address 10) reads 0x80. The time is 00:00:00, day of week 1, date 01/01, year 00, century 20.
- R2: Register B bit 2 selects the encoding of every time and date byte (addresses 0..7) for both reads and writes: 1 is binary, 0 is packed BCD.
- R3: Register B bit 1 set selects 24-hour hours (0..23). When it is clear, the hour byte (address 2) is 1..12 with bit 7 set for PM. 12 AM is midnight and 12 PM is noon.
- R4: While running, the time advances by one second after TICKS_PER_SEC enabled time-base ticks. Seconds carry into minutes, minutes into hours and hours into the day.
- R5: The day of month wraps to 1 after the month's last day: 30 for April, June, September and November, 31 for the other long months, and 28 for February, or 29 when the year is divisible by 4.
- R6: Day of week runs 1..7 and wraps to 1. Month runs 1..12. Year runs 0..99 and its wrap increments the century register (address 7).
- R7: While register B bit 7 (SET) is 1 the time does not advance, and writes to the time registers take effect.
- R8: Clearing SET while the divider field allows running restarts the sub-second count, so the next update comes exactly one second after that write.
- R9: The clock runs only when SET is 0 and register A bits 6:4 are 2 or less. Otherwise the time holds.
- R10: Register A bits 6:5 equal to 11 hold the divider in reset with the update-in-progress flag low. A write that removes this reset with SET clear places the first update half a second (TICKS_PER_SEC/2 ticks) later.
- R11: Register A bit 7 reads 1 during the final UIP_TICKS ticks before each update and 0 otherwise. Writes to that bit are ignored.
- R12: Register D is read-only and always reads 0x80. Addresses 11..15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse at the time-base rate |
| bus_addr | input | 4 | Register index for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, takes effect at the rising edge |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
A register write lands at the clock edge between two falling edges. Reads are combinational and are sampled one nanosecond after a falling edge. The write that clears SET counts as edge zero, and the time byte changes at edge TICKS_PER_SEC. The update-in-progress flag reads high from edge TICKS_PER_SEC-UIP_TICKS onward. After the divider leaves reset, the update lands at edge TICKS_PER_SEC/2. The bench counts exactly that many falling edges after each triggering write and samples on both sides of every due edge, so an early or late update is caught.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADR_W = 4;

    localparam logic [ADR_W-1:0] ADR_SEC   = 4'd0;
    localparam logic [ADR_W-1:0] ADR_MIN   = 4'd1;
    localparam logic [ADR_W-1:0] ADR_HOUR  = 4'd2;
    localparam logic [ADR_W-1:0] ADR_WDAY  = 4'd3;
    localparam logic [ADR_W-1:0] ADR_MDAY  = 4'd4;
    localparam logic [ADR_W-1:0] ADR_MONTH = 4'd5;
    localparam logic [ADR_W-1:0] ADR_YEAR  = 4'd6;
    localparam logic [ADR_W-1:0] ADR_CENT  = 4'd7;
    localparam logic [ADR_W-1:0] ADR_CTLA  = 4'd8;
    localparam logic [ADR_W-1:0] ADR_CTLB  = 4'd9;
    localparam logic [ADR_W-1:0] ADR_STAT  = 4'd10;

    localparam int B_SET = 7;
    localparam int B_BIN = 2;
    localparam int B_H24 = 1;

    localparam logic [6:0] CTLA_INIT = 7'h26;
    localparam logic [7:0] CTLB_INIT = 8'h02;
    localparam logic [7:0] STAT_VAL  = 8'h80;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] minute;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] month;
        logic [7:0] year;
        logic [7:0] cent;
    } cal_t;

    typedef struct packed {
        logic [6:0] a;
        logic [7:0] b;
    } ctl_t;

    localparam cal_t CAL_INIT = '{sec: 8'd0, minute: 8'd0, hour: 8'd0, wday: 8'd1,
                                  mday: 8'd1, month: 8'd1, year: 8'd0, cent: 8'd20};

    function automatic logic [7:0] to_bcd(input logic [7:0] v);
        return {4'(v / 8'd10), 4'(v % 8'd10)};
    endfunction

    function automatic logic [7:0] from_bcd(input logic [7:0] v);
        return (8'(v[7:4]) * 8'd10) + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic hold,
    input  logic load_half,
    input  logic restart,
    output logic uip,
    output logic sec_pulse
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF      = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] UIP_START = CW'(TICKS_PER_SEC - UIP_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        sec_pulse = 1'b0;
        if (load_half) begin
            st_d.cnt = HALF;
        end else if (hold || restart) begin
            st_d.cnt = '0;
        end else if (run && tick_en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                sec_pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        uip = run && (st_q.cnt >= UIP_START);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: no update unless the clock is allowed to run
    p_pulse_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (run && tick_en));
    // R11: the flag is up whenever an update fires
    p_uip_before_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> uip);
    // R11: stopped clock never shows the flag
    p_uip_only_running_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !uip);
    // R8: restart begins a full second
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !load_half) |=> (st_q.cnt == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            wr_en,
    input  logic [3:0]      wr_sel,
    input  logic [7:0]      wr_val,
    output rtc_pkg::cal_t   cal
);
    import rtc_pkg::*;

    cal_t cal_d, cal_q;
    logic [7:0] mlen;

    always_comb begin
        cal_d = cal_q;
        mlen  = month_len(cal_q.month, cal_q.year);
        if (advance) begin
            if (cal_q.sec >= 8'd59) begin
                cal_d.sec = 8'd0;
                if (cal_q.minute >= 8'd59) begin
                    cal_d.minute = 8'd0;
                    if (cal_q.hour >= 8'd23) begin
                        cal_d.hour = 8'd0;
                        cal_d.wday = (cal_q.wday >= 8'd7) ? 8'd1 : cal_q.wday + 8'd1;
                        if (cal_q.mday >= mlen) begin
                            cal_d.mday = 8'd1;
                            if (cal_q.month >= 8'd12) begin
                                cal_d.month = 8'd1;
                                if (cal_q.year >= 8'd99) begin
                                    cal_d.year = 8'd0;
                                    cal_d.cent = (cal_q.cent >= 8'd99) ? 8'd0 : cal_q.cent + 8'd1;
                                end else begin
                                    cal_d.year = cal_q.year + 8'd1;
                                end
                            end else begin
                                cal_d.month = cal_q.month + 8'd1;
                            end
                        end else begin
                            cal_d.mday = cal_q.mday + 8'd1;
                        end
                    end else begin
                        cal_d.hour = cal_q.hour + 8'd1;
                    end
                end else begin
                    cal_d.minute = cal_q.minute + 8'd1;
                end
            end else begin
                cal_d.sec = cal_q.sec + 8'd1;
            end
        end
        if (wr_en) begin
            case (wr_sel)
                ADR_SEC:   cal_d.sec    = wr_val;
                ADR_MIN:   cal_d.minute = wr_val;
                ADR_HOUR:  cal_d.hour   = wr_val;
                ADR_WDAY:  cal_d.wday   = wr_val;
                ADR_MDAY:  cal_d.mday   = wr_val;
                ADR_MONTH: cal_d.month  = wr_val;
                ADR_YEAR:  cal_d.year   = wr_val;
                ADR_CENT:  cal_d.cent   = wr_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_INIT;
        else        cal_q <= cal_d;
    end

    assign cal = cal_q;

    // R4: one step per update
    p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_en && cal_q.sec < 8'd59) |=> (cal_q.sec == $past(cal_q.sec) + 8'd1));
    // R7: nothing moves without an update or a write
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !wr_en) |=> $stable(cal_q));
    // R5: leap-year February reaches day 29
    p_leap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_en && cal_q.sec >= 8'd59 && cal_q.minute >= 8'd59 &&
         cal_q.hour >= 8'd23 && cal_q.month == 8'd2 && cal_q.mday == 8'd28 &&
         cal_q.year[1:0] == 2'b00) |=> (cal_q.mday == 8'd29));
endmodule

// File: rtl/rtc_field_codec.sv
module rtc_field_codec (
    input  logic            bin_mode,
    input  logic            hour24,
    input  rtc_pkg::cal_t   cal,
    input  logic [3:0]      sel,
    input  logic [7:0]      wr_byte,
    output logic [7:0]      rd_byte,
    output logic [7:0]      wr_value
);
    import rtc_pkg::*;

    logic [7:0] h12;
    logic [7:0] h_enc;
    logic [7:0] w_low;
    logic [7:0] w_hr;

    function automatic logic [7:0] enc(input logic bm, input logic [7:0] v);
        return bm ? v : to_bcd(v);
    endfunction

    function automatic logic [7:0] dec(input logic bm, input logic [7:0] v);
        return bm ? v : from_bcd(v);
    endfunction

    always_comb begin
        h12   = ((cal.hour % 8'd12) == 8'd0) ? 8'd12 : (cal.hour % 8'd12);
        h_enc = hour24 ? enc(bin_mode, cal.hour)
                       : {(cal.hour >= 8'd12), enc(bin_mode, h12)[6:0]};
        case (sel)
            ADR_SEC:   rd_byte = enc(bin_mode, cal.sec);
            ADR_MIN:   rd_byte = enc(bin_mode, cal.minute);
            ADR_HOUR:  rd_byte = h_enc;
            ADR_WDAY:  rd_byte = enc(bin_mode, cal.wday);
            ADR_MDAY:  rd_byte = enc(bin_mode, cal.mday);
            ADR_MONTH: rd_byte = enc(bin_mode, cal.month);
            ADR_YEAR:  rd_byte = enc(bin_mode, cal.year);
            ADR_CENT:  rd_byte = enc(bin_mode, cal.cent);
            default:   rd_byte = 8'h00;
        endcase

        w_low = dec(bin_mode, {1'b0, wr_byte[6:0]});
        w_hr  = ((w_low == 8'd12) ? 8'd0 : w_low) + (wr_byte[7] ? 8'd12 : 8'd0);
        if (sel == ADR_HOUR && !hour24) wr_value = w_hr;
        else                            wr_value = dec(bin_mode, wr_byte);
    end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    output logic [7:0] bus_rdata
);
    import rtc_pkg::*;

    ctl_t ctl_d, ctl_q;
    cal_t cal;
    logic wr_a, wr_b, wr_time;
    logic run, hold, load_half, restart;
    logic uip, sec_pulse;
    logic [7:0] time_rd, time_wr;

    always_comb begin
        ctl_d   = ctl_q;
        wr_a    = bus_we && (bus_addr == ADR_CTLA);
        wr_b    = bus_we && (bus_addr == ADR_CTLB);
        wr_time = bus_we && (bus_addr <= ADR_CENT);
        if (wr_a) ctl_d.a = bus_wdata[6:0];
        if (wr_b) ctl_d.b = bus_wdata;

        run       = !ctl_q.b[B_SET] && (ctl_q.a[6:4] <= 3'd2);
        hold      = (ctl_q.a[6:5] == 2'b11);
        load_half = wr_a && hold && (bus_wdata[6:4] <= 3'd2) && !ctl_q.b[B_SET];
        restart   = wr_b && ctl_q.b[B_SET] && !bus_wdata[B_SET] && (ctl_q.a[6:4] <= 3'd2);

        case (bus_addr)
            ADR_CTLA: bus_rdata = {uip, ctl_q.a};
            ADR_CTLB: bus_rdata = ctl_q.b;
            ADR_STAT: bus_rdata = STAT_VAL;
            default:  bus_rdata = time_rd;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{a: CTLA_INIT, b: CTLB_INIT};
        else        ctl_q <= ctl_d;
    end

    rtc_divider #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run      (run),
        .hold     (hold),
        .load_half(load_half),
        .restart  (restart),
        .uip      (uip),
        .sec_pulse(sec_pulse)
    );

    rtc_field_codec u_codec (
        .bin_mode(ctl_q.b[B_BIN]),
        .hour24  (ctl_q.b[B_H24]),
        .cal     (cal),
        .sel     (bus_addr),
        .wr_byte (bus_wdata),
        .rd_byte (time_rd),
        .wr_value(time_wr)
    );

    rtc_calendar u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(sec_pulse),
        .wr_en  (wr_time),
        .wr_sel (bus_addr),
        .wr_val (time_wr),
        .cal    (cal)
    );

    // R10: divider in reset keeps the flag low
    p_div_hold_uip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !uip);
    // R7: freeze blocks every update
    p_set_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.b[B_SET] |-> !sec_pulse);
    // R12: status register never changes
    p_stat_const_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_STAT) |-> (bus_rdata == STAT_VAL));
endmodule

// File: tb/rtc_timekeeper_test.sv
module rtc_timekeeper_test;
    localparam int TPS = 64;
    localparam int UT  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_timekeeper #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UT)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_addr = a;
        #1;
        v = bus_rdata;
        checks++;
        if (v !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual 0x%02h expected 0x%02h", tag, a, v, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_time(input logic [7:0] s, m, h, wd, md, mo, yr, ce);
        wr(4'd9, 8'h82);
        wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, wd);
        wr(4'd4, md); wr(4'd5, mo); wr(4'd6, yr); wr(4'd7, ce);
        wr(4'd9, 8'h02);
    endtask

    task automatic t_reset;
        expect_reg("R1 ctrl A", 4'd8, 8'h26);
        expect_reg("R1 ctrl B", 4'd9, 8'h02);
        expect_reg("R1 status", 4'd10, 8'h80);
        expect_reg("R1 seconds", 4'd0, 8'h00);
        expect_reg("R1 century", 4'd7, 8'h20);
    endtask

    task automatic t_formats;
        wr(4'd9, 8'h82);
        wr(4'd2, 8'h23);
        expect_reg("R3 24h bcd", 4'd2, 8'h23);
        wr(4'd9, 8'h80);
        expect_reg("R3 12h pm bcd", 4'd2, 8'h91);
        wr(4'd9, 8'h84);
        expect_reg("R2 12h pm binary", 4'd2, 8'h8B);
        wr(4'd9, 8'h86);
        expect_reg("R2 24h binary", 4'd2, 8'h17);
        wr(4'd9, 8'h80);
        wr(4'd2, 8'h12);
        wr(4'd9, 8'h82);
        expect_reg("R3 12 am is midnight", 4'd2, 8'h00);
        wr(4'd9, 8'h80);
        wr(4'd2, 8'h92);
        wr(4'd9, 8'h82);
        expect_reg("R3 12 pm is noon", 4'd2, 8'h12);
        wr(4'd9, 8'h86);
        wr(4'd1, 8'd45);
        wr(4'd9, 8'h82);
        expect_reg("R2 binary write bcd read", 4'd1, 8'h45);
    endtask

    task automatic t_freeze;
        wr(4'd9, 8'h82);
        wr(4'd0, 8'h10);
        wait_edges(3 * TPS);
        expect_reg("R7 frozen seconds", 4'd0, 8'h10);
    endtask

    task automatic t_rollover;
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
        wait_edges(TPS - UT - 1);
        expect_reg("R11 flag low before window", 4'd8, 8'h26);
        wait_edges(1);
        expect_reg("R11 flag high in window", 4'd8, 8'hA6);
        wait_edges(UT - 1);
        expect_reg("R8 no update before full second", 4'd0, 8'h59);
        wait_edges(1);
        expect_reg("R4 seconds wrap", 4'd0, 8'h00);
        expect_reg("R4 minutes wrap", 4'd1, 8'h00);
        expect_reg("R4 hours wrap", 4'd2, 8'h00);
        expect_reg("R6 weekday wrap", 4'd3, 8'h01);
        expect_reg("R5 day wrap", 4'd4, 8'h01);
        expect_reg("R6 month wrap", 4'd5, 8'h01);
        expect_reg("R6 year wrap", 4'd6, 8'h00);
        expect_reg("R6 century step", 4'd7, 8'h21);
        expect_reg("R11 flag clear after update", 4'd8, 8'h26);
    endtask

    task automatic month_end(input string tag, input logic [7:0] md, mo, yr,
                             input logic [7:0] exp_md, exp_mo);
        load_time(8'h59, 8'h59, 8'h23, 8'h02, md, mo, yr, 8'h20);
        wait_edges(TPS);
        expect_reg(tag, 4'd4, exp_md);
        expect_reg(tag, 4'd5, exp_mo);
    endtask

    task automatic t_months;
        month_end("R5 leap february", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        month_end("R5 plain february", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        month_end("R5 thirty day month", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
        month_end("R5 long month", 8'h30, 8'h01, 8'h23, 8'h31, 8'h01);
    endtask

    task automatic t_divider_field;
        wr(4'd9, 8'h82);
        wr(4'd0, 8'h20);
        wr(4'd8, 8'h36);
        wr(4'd9, 8'h02);
        wait_edges(3 * TPS);
        expect_reg("R9 halted seconds", 4'd0, 8'h20);
        expect_reg("R9 ctrl A readback", 4'd8, 8'h36);
    endtask

    task automatic t_divider_reset;
        wr(4'd8, 8'h66);
        expect_reg("R10 flag low in reset", 4'd8, 8'h66);
        wr(4'd0, 8'h30);
        wait_edges(2 * TPS);
        expect_reg("R10 held in reset", 4'd0, 8'h30);
        wr(4'd8, 8'h26);
        wait_edges(TPS / 2 - 1);
        expect_reg("R10 before half second", 4'd0, 8'h30);
        wait_edges(1);
        expect_reg("R10 update at half second", 4'd0, 8'h31);
    endtask

    task automatic t_flag_write;
        wr(4'd8, 8'hA6);
        expect_reg("R11 flag write ignored", 4'd8, 8'h26);
    endtask

    task automatic t_status;
        wr(4'd10, 8'h00);
        expect_reg("R12 status read-only", 4'd10, 8'h80);
        expect_reg("R12 unused address", 4'd15, 8'h00);
    endtask

    initial begin
        wait_edges(3);
        rst_n = 1'b1;
        t_reset();
        t_formats();
        t_freeze();
        t_rollover();
        t_months();
        t_divider_field();
        t_divider_reset();
        t_flag_write();
        t_status();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule